// File: doc/BRIEF.md
# Interrupt and Wake Event Controller

This block gathers five event sources of a small controller (a divider overflow, a first timer underflow, a port pin change, a falling edge on an external pin and a second timer underflow) into an eight-bit event register. From there it raises a vectored interrupt request toward the core and decides whether a low-power hold state may be entered or must be left.

Software programs an interrupt enable register and a hold-release enable register through write strobes that share one data bus. It clears event bits with a mask, and it opens or closes a global interrupt gate. When the core accepts the request, the block clears the event bit of the granted source only and closes the global gate. A read-only release-condition register shows which enabled events hold the core awake. A hold request is refused while any of its bits is set, and an active hold ends as soon as one appears.

Top module: `wake_irq_hub`

## Requirements
- R1: Event register positions are fixed: bit 0 divider overflow, bit 1 first timer underflow, bit 2 port change, bit 4 external pin falling edge, bit 7 second timer underflow (`evt_pulse` index 0..4 in that order). Bits 3, 5 and 6 of every register read zero, and writes to them are dropped.
- R2: The vector is 0x004, 0x008, 0x00C, 0x014 or 0x020 for bit 0, 1, 2, 4 or 7. When several sources are pending, the lowest bit position wins.
- R3: A source is pending when its event bit and its interrupt enable bit are both 1. For bit 2 at least one bit of `port_en` must also be 1. `irq_req` is high when the global gate is open and some source is pending.
- R4: `evt_clr` clears the event bits that are 1 in `reg_wdata`. An accepted interrupt clears only the granted source's bit. All other bits keep their value.
- R5: In the cycle after an accept (`irq_req` and `irq_ack` both high), the global gate is closed and `irq_req` is low. `gie_clr` also closes it. `gie_set` or a write to the interrupt enable register opens it. A close and an open in the same cycle leave it closed.
- R6: `rcf_q` equals `evt_q & hen_q` at all times, so a bit drops in the same cycle that its event bit or its hold-release enable bit is cleared.
- R7: `hold_req` sets `hold_active` only when `rcf_q` is zero. Any nonzero `rcf_q` clears `hold_active` on the next edge.
- R8: After reset the event, interrupt enable, hold-release enable and release-condition registers are zero, the gate is closed, and `irq_req` and `hold_active` are low.
- R9: An event pulse that arrives in the same cycle as a clear or an accept of that bit leaves the bit set.
- R10: Each accept clears exactly one source. `irq_ack` while `irq_req` is low has no effect on any register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_pulse | input | 5 | Single-cycle event pulses, one per source |
| port_en | input | 4 | Per-pin port enables; at least one must be set for the port source to interrupt |
| reg_wdata | input | 8 | Data or mask for the write strobes |
| ien_wr | input | 1 | Load the interrupt enable register and open the gate |
| hen_wr | input | 1 | Load the hold-release enable register |
| evt_clr | input | 1 | Clear the event bits selected by `reg_wdata` |
| gie_set | input | 1 | Open the global interrupt gate |
| gie_clr | input | 1 | Close the global interrupt gate |
| irq_ack | input | 1 | The core accepts the presented vector |
| hold_req | input | 1 | The core asks to enter hold |
| irq_req | output | 1 | Interrupt request |
| irq_vec | output | 11 | Vector address of the granted source |
| evt_q | output | 8 | Event register |
| ien_q | output | 8 | Interrupt enable register |
| hen_q | output | 8 | Hold-release enable register |
| rcf_q | output | 8 | Release-condition register (read-only) |
| hold_active | output | 1 | The core is held |

## Verification
The assertions assume that every strobe is a single-cycle, synchronous pulse. They also assume that `irq_ack` only has meaning while `irq_req` is high, and that `hold_req` comes from the core rather than from an event source. The bench drives every input once per cycle, just after the falling edge, and pulses each strobe for one cycle only. It also drives `irq_ack` once with no request pending and with all registers otherwise unchanged, and checks that nothing moves. The sweep presents every one of the 32 source combinations, so the priority encoder and the single-bit accept clear are each exercised for every subset of sources.

// File: rtl/wih_pkg.sv
package wih_pkg;
    localparam int unsigned REG_W  = 8;
    localparam int unsigned NSRC   = 5;
    localparam int unsigned VEC_W  = 11;
    localparam int unsigned SRC_W  = $clog2(NSRC);
    localparam logic [REG_W-1:0] LIVE_MASK = 8'h97;

    typedef enum logic [SRC_W-1:0] {
        SRC_DIV  = 3'd0,
        SRC_TM0  = 3'd1,
        SRC_PORT = 3'd2,
        SRC_PIN  = 3'd3,
        SRC_TM1  = 3'd4
    } src_e;

    typedef struct packed {
        logic             valid;
        logic [SRC_W-1:0] src;
        logic [VEC_W-1:0] vec;
    } grant_t;

    // register bit position owned by source index s
    function automatic int unsigned src_pos(input int unsigned s);
        case (s)
            0: return 0;
            1: return 1;
            2: return 2;
            3: return 4;
            default: return 7;
        endcase
    endfunction

    // vector address: four words per bit position, starting after word 0
    function automatic logic [VEC_W-1:0] src_vector(input int unsigned s);
        return VEC_W'((src_pos(s) + 1) * 4);
    endfunction
endpackage

// File: rtl/wih_mask_reg.sv
module wih_mask_reg
    import wih_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (wr)
            q <= wdata & LIVE_MASK;
    end
endmodule

// File: rtl/wih_evt_reg.sv
module wih_evt_reg
    import wih_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NSRC-1:0]  set_pulse,
    input  logic             clr_en,
    input  logic [REG_W-1:0] clr_mask,
    input  logic             ack_en,
    input  logic [SRC_W-1:0] ack_src,
    output logic [REG_W-1:0] evt_q
);
    logic [REG_W-1:0] set_vec;
    logic [REG_W-1:0] ack_vec;
    logic [REG_W-1:0] drop_vec;

    always_comb begin
        set_vec = '0;
        ack_vec = '0;
        for (int unsigned s = 0; s < NSRC; s++) begin
            set_vec[src_pos(s)] = set_pulse[s];
            if (ack_en && (ack_src == SRC_W'(s)))
                ack_vec[src_pos(s)] = 1'b1;
        end
        drop_vec = (clr_en ? clr_mask : '0) | ack_vec;
    end

    for (genvar b = 0; b < REG_W; b++) begin : g_bit
        if (LIVE_MASK[b]) begin : g_live
            always_ff @(posedge clk) begin
                if (rst)
                    evt_q[b] <= 1'b0;
                else if (set_vec[b])
                    evt_q[b] <= 1'b1;
                else if (drop_vec[b])
                    evt_q[b] <= 1'b0;
            end
        end else begin : g_rsv
            assign evt_q[b] = 1'b0;
        end
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (|set_vec) |=> ((evt_q & $past(set_vec)) == $past(set_vec))); // R9
    AST_CLR_MASK: assert property (@(posedge clk) disable iff (rst)
        clr_en |=> ((evt_q & $past(clr_mask & ~set_vec)) == '0)); // R4
    AST_ACK_ONE: assert property (@(posedge clk) disable iff (rst)
        (ack_en && !clr_en && !(|set_vec)) |=>
            ($countones($past(evt_q) ^ evt_q) <= 1)); // R10
endmodule

// File: rtl/wih_prio.sv
module wih_prio
    import wih_pkg::*;
(
    input  logic [REG_W-1:0] pend,
    output grant_t           grant
);
    always_comb begin
        grant = '0;
        for (int s = NSRC - 1; s >= 0; s--) begin
            if (pend[src_pos(s)]) begin
                grant.valid = 1'b1;
                grant.src   = SRC_W'(s);
                grant.vec   = src_vector(s);
            end
        end
    end
endmodule

// File: rtl/wih_hold.sv
module wih_hold
    import wih_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             hold_req,
    input  logic [REG_W-1:0] rcf,
    output logic             hold_active
);
    always_ff @(posedge clk) begin
        if (rst)
            hold_active <= 1'b0;
        else if (|rcf)
            hold_active <= 1'b0;
        else if (hold_req)
            hold_active <= 1'b1;
    end

    AST_HOLD_REFUSED: assert property (@(posedge clk) disable iff (rst)
        (hold_req && (|rcf)) |=> !hold_active); // R7
    AST_HOLD_ENTER: assert property (@(posedge clk) disable iff (rst)
        (hold_req && !(|rcf)) |=> hold_active); // R7
endmodule

// File: rtl/wake_irq_hub.sv
module wake_irq_hub
    import wih_pkg::*;
#(
    parameter int unsigned PORT_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NSRC-1:0]   evt_pulse,
    input  logic [PORT_W-1:0] port_en,
    input  logic [REG_W-1:0]  reg_wdata,
    input  logic              ien_wr,
    input  logic              hen_wr,
    input  logic              evt_clr,
    input  logic              gie_set,
    input  logic              gie_clr,
    input  logic              irq_ack,
    input  logic              hold_req,
    output logic              irq_req,
    output logic [VEC_W-1:0]  irq_vec,
    output logic [REG_W-1:0]  evt_q,
    output logic [REG_W-1:0]  ien_q,
    output logic [REG_W-1:0]  hen_q,
    output logic [REG_W-1:0]  rcf_q,
    output logic              hold_active
);
    localparam int unsigned PORT_POS = src_pos(SRC_PORT);

    logic             gie_q;
    logic [REG_W-1:0] pend;
    logic [REG_W-1:0] port_gate;
    grant_t           grant;
    logic             accept;

    wih_mask_reg i_ien (
        .clk(clk), .rst(rst), .wr(ien_wr), .wdata(reg_wdata), .q(ien_q)
    );
    wih_mask_reg i_hen (
        .clk(clk), .rst(rst), .wr(hen_wr), .wdata(reg_wdata), .q(hen_q)
    );

    wih_evt_reg i_evt (
        .clk(clk), .rst(rst),
        .set_pulse(evt_pulse),
        .clr_en(evt_clr), .clr_mask(reg_wdata),
        .ack_en(accept), .ack_src(grant.src),
        .evt_q(evt_q)
    );

    always_comb begin
        port_gate           = '1;
        port_gate[PORT_POS] = |port_en;
        pend                = evt_q & ien_q & port_gate;
    end

    wih_prio i_prio (.pend(pend), .grant(grant));

    assign irq_req = gie_q & grant.valid;
    assign irq_vec = grant.vec;
    assign accept  = irq_req & irq_ack;
    assign rcf_q   = evt_q & hen_q;

    always_ff @(posedge clk) begin
        if (rst)
            gie_q <= 1'b0;
        else if (gie_clr || accept)
            gie_q <= 1'b0;
        else if (gie_set || ien_wr)
            gie_q <= 1'b1;
    end

    wih_hold i_hold (
        .clk(clk), .rst(rst), .hold_req(hold_req), .rcf(rcf_q),
        .hold_active(hold_active)
    );

    AST_ACK_INHIBIT: assert property (@(posedge clk) disable iff (rst)
        accept |=> !irq_req); // R5
    AST_REQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> (|(evt_q & ien_q))); // R3
    AST_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (|rcf_q) |=> !hold_active); // R7
    AST_DISABLE: assert property (@(posedge clk) disable iff (rst)
        gie_clr |=> !irq_req); // R5
endmodule

// File: tb/test_wake_irq_hub.sv
module test_wake_irq_hub;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  evt_pulse = '0;
    logic [3:0]  port_en = '0;
    logic [7:0]  reg_wdata = '0;
    logic        ien_wr = 0, hen_wr = 0, evt_clr = 0, gie_set = 0, gie_clr = 0;
    logic        irq_ack = 0, hold_req = 0;
    logic        irq_req, hold_active;
    logic [10:0] irq_vec;
    logic [7:0]  evt_q, ien_q, hen_q, rcf_q;

    int checks = 0;
    int errs   = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    wake_irq_hub i_wake_irq_hub (
        .clk(clk), .rst(rst), .evt_pulse(evt_pulse), .port_en(port_en),
        .reg_wdata(reg_wdata), .ien_wr(ien_wr), .hen_wr(hen_wr),
        .evt_clr(evt_clr), .gie_set(gie_set), .gie_clr(gie_clr),
        .irq_ack(irq_ack), .hold_req(hold_req), .irq_req(irq_req),
        .irq_vec(irq_vec), .evt_q(evt_q), .ien_q(ien_q), .hen_q(hen_q),
        .rcf_q(rcf_q), .hold_active(hold_active)
    );

    function automatic int bitpos(input int s);
        return (s < 3) ? s : ((s == 3) ? 4 : 7);
    endfunction

    function automatic logic [7:0] map5(input logic [4:0] m);
        logic [7:0] r = '0;
        for (int s = 0; s < 5; s++) if (m[s]) r[bitpos(s)] = 1'b1;
        return r;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic step;
        @(negedge clk);
        evt_pulse = '0; ien_wr = 0; hen_wr = 0; evt_clr = 0;
        gie_set = 0; gie_clr = 0; irq_ack = 0; hold_req = 0;
    endtask

    task automatic pulse(input logic [4:0] m); evt_pulse = m; step(); endtask
    task automatic wr_ie(input logic [7:0] d); reg_wdata = d; ien_wr = 1; step(); endtask
    task automatic wr_he(input logic [7:0] d); reg_wdata = d; hen_wr = 1; step(); endtask
    task automatic clr_ev(input logic [7:0] d); reg_wdata = d; evt_clr = 1; step(); endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errs++;
            $display("FAIL watchdog: actual 0x1 expected 0x0");
            $display("  == %0d vectors applied, %0d miscompares ==", checks, errs);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        step();
        // R8 reset state
        chk("R8 evt", evt_q, 0); chk("R8 ien", ien_q, 0);
        chk("R8 hen", hen_q, 0); chk("R8 rcf", rcf_q, 0);
        chk("R8 irq", irq_req, 0); chk("R8 hold", hold_active, 0);

        // R1 positions and reserved bits
        for (int s = 0; s < 5; s++) begin
            clr_ev(8'hFF);
            pulse(5'(1 << s));
            chk("R1 position", evt_q, 1 << bitpos(s));
        end
        wr_ie(8'hFF); chk("R1 reserved ien", ien_q, 8'h97);
        wr_he(8'hFF); chk("R1 reserved hen", hen_q, 8'h97);
        wr_he(8'h00);

        // R2 R3 R4 R5 R10 sweep over all source combinations
        port_en = 4'b0100;
        for (int c = 0; c < 32; c++) begin
            int lo;
            logic [7:0] expv;
            clr_ev(8'hFF);
            pulse(5'(c));
            wr_ie(8'hFF);
            expv = map5(5'(c));
            chk("R1 evt map", evt_q, expv);
            chk("R3 request", irq_req, (c != 0));
            if (c != 0) begin
                lo = 0;
                while (!c[lo]) lo++;
                chk("R2 vector", irq_vec, (bitpos(lo) + 1) * 4);
                irq_ack = 1; step();
                chk("R5 inhibit", irq_req, 0);
                chk("R4 r10_one clear", evt_q, expv & ~(8'(1) << bitpos(lo)));
            end
        end

        // R3 port gate and enable bit
        clr_ev(8'hFF);
        port_en = 4'b0000;
        pulse(5'b00100); wr_ie(8'hFF);
        chk("R3 port gate closed", irq_req, 0);
        port_en = 4'b1000; step();
        chk("R3 port gate open", irq_req, 1);
        chk("R3 port vector", irq_vec, 12);
        wr_ie(8'hFB); chk("R3 enable off", irq_req, 0);

        // R5 global disable and re-enable
        wr_ie(8'hFF); gie_clr = 1; step();
        chk("R5 disable", irq_req, 0);
        gie_set = 1; step(); chk("R5 enable", irq_req, 1);
        gie_set = 1; gie_clr = 1; step(); chk("R5 close wins", irq_req, 0);

        // R10 ack without request
        clr_ev(8'hFF); pulse(5'b10001);
        irq_ack = 1; step();
        chk("R10 stray ack", evt_q, 8'h81);

        // R4 masked clear, R9 set beats clear and accept
        clr_ev(8'h01); chk("R4 mask clear", evt_q, 8'h80);
        reg_wdata = 8'h80; evt_clr = 1; evt_pulse = 5'b10000; step();
        chk("R9 set beats clear", evt_q, 8'h80);
        wr_ie(8'h80); chk("R9 pre", irq_req, 1);
        irq_ack = 1; evt_pulse = 5'b10000; step();
        chk("R9 set beats accept", evt_q, 8'h80);

        // R6 R7 release and hold
        clr_ev(8'hFF); wr_ie(8'h00);
        wr_he(8'h02); chk("R6 rcf empty", rcf_q, 0);
        hold_req = 1; step(); chk("R7 enter hold", hold_active, 1);
        pulse(5'b00010);
        chk("R6 rcf set", rcf_q, 8'h02);
        chk("R7 still held", hold_active, 1);
        step(); chk("R7 released", hold_active, 0);
        hold_req = 1; step(); chk("R7 hold refused", hold_active, 0);
        wr_he(8'h00); chk("R6 hen clear", rcf_q, 0);
        wr_he(8'h02); chk("R6 rcf back", rcf_q, 8'h02);
        clr_ev(8'h02); chk("R6 evt clear", rcf_q, 0);
        hold_req = 1; step(); chk("R7 enter again", hold_active, 1);

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", checks, errs);
        $finish;
    end
endmodule